// File: doc/BRIEF.md
# SPI Slave Bus Timing Monitor

This block observes the select, serial clock and data-in lines of an SPI slave port after they have been synchronised to a faster system clock. It counts system-clock cycles between bus events and raises a sticky flag when an event comes too soon after the previous one. All limits are whole numbers of system-clock cycles. The checked spacings are:

- the high and low phases of the serial clock;
- the clock period;
- the interval from select to the first clock edge;
- the interval from the last clock edge to release;
- the idle gap between two selections.

It also flags serial-clock activity while the port is deselected. It assembles the incoming bits most-significant first and pulses once per completed word, so the bit framing that the clock mode implies can be observed alongside the timing.

The spacing rules around the select line are tracked by a four-state machine:

- `ST_IDLE`: deselected and rested.
- `ST_ARMED`: selected, with no clock edge seen yet.
- `ST_CLOCKING`: selected, and at least one edge seen.
- `ST_RECOVER`: released, and the minimum gap has not yet elapsed.

Its transitions are:

- IDLE→ARMED when select asserts with no clock edge in that cycle.
- IDLE→CLOCKING when select asserts together with a clock edge.
- ARMED→CLOCKING on the first clock edge.
- ARMED→RECOVER when select is released.
- CLOCKING→RECOVER when select is released.
- RECOVER→ARMED or RECOVER→CLOCKING on a new select, depending on whether a clock edge comes in the same cycle.
- RECOVER→IDLE once the gap counter reaches the minimum.

Clock width and period are checked by a separate counter unit. Word assembly is done by a shift unit.

Top module: `sspi_timing_mon`

## Requirements
- R1: After reset all seven bits of `viol` are 0 and `word_done` is 0.
- R2: While selected, a clock high phase (rise to fall) shorter than `MIN_HI` cycles sets `viol[0]`.
- R3: While selected, a clock low phase (fall to rise) shorter than `MIN_LO` cycles sets `viol[1]`.
- R4: While selected, two consecutive rising edges, or two consecutive falling edges, fewer than `MIN_PER` cycles apart set `viol[2]`.
- R5: A first clock edge fewer than `MIN_SETUP` cycles after `cs_n` falls sets `viol[3]`. This includes an edge in the same cycle as the fall.
- R6: A `cs_n` rise fewer than `MIN_HOLD` cycles after the last clock edge of a selection sets `viol[4]`. This includes an edge in the same cycle as the rise.
- R7: A `cs_n` fall fewer than `MIN_GAP` cycles after the preceding `cs_n` rise sets `viol[5]`.
- R8: A clock edge while `cs_n` is high, other than in the cycle `cs_n` rises, sets `viol[6]` and takes no part in the width or period checks.
- R9: Each `viol` bit stays set until a cycle with `clr` high. `clr` zeroes all bits, except that a violation detected in the same cycle still sets its bit.
- R10: The sampling edge is the rising edge when `cpol` XOR `cpha` is 0, and the falling edge otherwise. Bits enter MSB first. On the `WORD_BITS`-th sampling edge of a selection, `rx_word` takes the word and `word_done` is high for exactly the next cycle.
- R11: In all four clock modes, a transfer that keeps every limit sets no flag and delivers exactly one word per `WORD_BITS` sampling edges.
- R12: A release of `cs_n` discards a partly received word, and the next selection starts counting bits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of all violation flags |
| cs_n | input | 1 | Synchronised slave select, active low |
| sck | input | 1 | Synchronised serial clock |
| mosi | input | 1 | Synchronised serial data into the slave |
| cpol | input | 1 | Idle clock level (0 low, 1 high) |
| cpha | input | 1 | 0: sample on the leading edge, 1: on the trailing edge |
| viol | output | 7 | Sticky flags: 0 high, 1 low, 2 period, 3 setup, 4 hold, 5 gap, 6 stray |
| word_done | output | 1 | One-cycle pulse after a word completes |
| rx_word | output | WORD_BITS | Last completed word |

## Verification
The bound checker watches, on every cycle, that each flag only sets in a cycle whose select level fits its rule:

- setup and gap flags set only while selected;
- hold and stray flags set only while deselected;
- flags never drop without a clear;
- a word pulse lasts one cycle and follows a selected cycle.

Whether a flag fires at exactly the right cycle count can only be shown by the bench. It sweeps phase lengths, setup and hold spacings across all four clock modes and compares each flag pattern and received word with values computed from the limits. Directed scenarios cover the gap rule, stray clocks, clear-versus-set precedence and aborted words.

// File: rtl/stm_pkg.sv
`timescale 1ns/1ps
package stm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CLOCKING,
        ST_RECOVER
    } mon_state_t;

    localparam int FLG_HI     = 0;
    localparam int FLG_LO     = 1;
    localparam int FLG_PER    = 2;
    localparam int FLG_SETUP  = 3;
    localparam int FLG_HOLD   = 4;
    localparam int FLG_GAP    = 5;
    localparam int FLG_STRAY  = 6;
    localparam int NUM_FLAGS  = 7;

endpackage

// File: rtl/stm_edges.sv
`timescale 1ns/1ps
module stm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall
);
    logic cs_q;
    logic sck_q;
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sck_q  <= 1'b0;
            primed <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sck_q  <= sck;
            primed <= 1'b1;
        end
    end

    // the first cycle after reset has no valid history for the clock line
    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign sck_rise = primed & ~sck_q & sck;
    assign sck_fall = primed & sck_q & ~sck;
endmodule

// File: rtl/stm_sck_width.sv
`timescale 1ns/1ps
module stm_sck_width #(
    parameter int MIN_HI  = 2,
    parameter int MIN_LO  = 2,
    parameter int MIN_PER = 4,
    parameter int CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rise,
    input  logic fall,
    output logic hi_short,
    output logic lo_short,
    output logic per_short
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] LIM_HI  = CW'(MIN_HI);
    localparam logic [CW-1:0] LIM_LO  = CW'(MIN_LO);
    localparam logic [CW-1:0] LIM_PER = CW'(MIN_PER);

    logic [CW-1:0] ph_cnt, r_cnt, f_cnt;
    logic          ph_ok, r_ok, f_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            r_cnt  <= '0;
            f_cnt  <= '0;
            ph_ok  <= 1'b0;
            r_ok   <= 1'b0;
            f_ok   <= 1'b0;
        end else if (!sel) begin
            ph_ok  <= 1'b0;
            r_ok   <= 1'b0;
            f_ok   <= 1'b0;
        end else begin
            if (rise || fall) begin
                ph_cnt <= CW'(1);
                ph_ok  <= 1'b1;
            end else if (ph_cnt != CNT_MAX) begin
                ph_cnt <= ph_cnt + 1'b1;
            end
            if (rise) begin
                r_cnt <= CW'(1);
                r_ok  <= 1'b1;
            end else if (r_cnt != CNT_MAX) begin
                r_cnt <= r_cnt + 1'b1;
            end
            if (fall) begin
                f_cnt <= CW'(1);
                f_ok  <= 1'b1;
            end else if (f_cnt != CNT_MAX) begin
                f_cnt <= f_cnt + 1'b1;
            end
        end
    end

    assign hi_short  = sel && fall && ph_ok && (ph_cnt < LIM_HI);
    assign lo_short  = sel && rise && ph_ok && (ph_cnt < LIM_LO);
    assign per_short = sel && ((rise && r_ok && (r_cnt < LIM_PER)) ||
                               (fall && f_ok && (f_cnt < LIM_PER)));
endmodule

// File: rtl/stm_word.sv
`timescale 1ns/1ps
module stm_word #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 smp,
    input  logic                 din,
    output logic                 done,
    output logic [WORD_BITS-1:0] word
);
    localparam int BW = $clog2(WORD_BITS + 1);
    localparam logic [BW-1:0] LAST = BW'(WORD_BITS - 1);

    logic [BW-1:0]        cnt;
    logic [WORD_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sh   <= '0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (!sel) begin
                cnt <= '0;
            end else if (smp) begin
                sh <= {sh[WORD_BITS-2:0], din};
                if (cnt == LAST) begin
                    cnt  <= '0;
                    done <= 1'b1;
                    word <= {sh[WORD_BITS-2:0], din};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sspi_timing_mon.sv
`timescale 1ns/1ps
module sspi_timing_mon
    import stm_pkg::*;
#(
    parameter int MIN_HI    = 2,
    parameter int MIN_LO    = 2,
    parameter int MIN_PER   = 4,
    parameter int MIN_SETUP = 2,
    parameter int MIN_HOLD  = 2,
    parameter int MIN_GAP   = 2,
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 mosi,
    input  logic                 cpol,
    input  logic                 cpha,
    output logic [NUM_FLAGS-1:0] viol,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] rx_word
);
    localparam int LIM_SUM = MIN_HI + MIN_LO + MIN_PER + MIN_SETUP + MIN_HOLD + MIN_GAP;
    localparam int CW      = $clog2(LIM_SUM + 1);
    localparam logic [CW-1:0] TMR_MAX   = '1;
    localparam logic [CW-1:0] LIM_SETUP = CW'(MIN_SETUP);
    localparam logic [CW-1:0] LIM_HOLD  = CW'(MIN_HOLD);
    localparam logic [CW-1:0] LIM_GAP   = CW'(MIN_GAP);

    logic cs_fall, cs_rise, sck_rise, sck_fall, sck_edge;
    logic sel, smp;
    logic hi_short, lo_short, per_short;

    mon_state_t    st, nxt;
    logic [CW-1:0] tmr;
    logic          tmr_rst;
    logic          setup_hit, hold_hit, gap_hit, stray_hit;
    logic [NUM_FLAGS-1:0] hits;

    stm_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    assign sck_edge = sck_rise | sck_fall;
    assign sel      = ~cs_n;
    // leading edge is the rise for idle-low, so XOR picks the sampling polarity
    assign smp      = (cpol ^ cpha) ? sck_fall : sck_rise;

    stm_sck_width #(
        .MIN_HI  (MIN_HI),
        .MIN_LO  (MIN_LO),
        .MIN_PER (MIN_PER),
        .CW      (CW)
    ) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rise      (sck_rise),
        .fall      (sck_fall),
        .hi_short  (hi_short),
        .lo_short  (lo_short),
        .per_short (per_short)
    );

    stm_word #(
        .WORD_BITS (WORD_BITS)
    ) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .smp   (smp),
        .din   (mosi),
        .done  (word_done),
        .word  (rx_word)
    );

    // next state and select-spacing checks
    always_comb begin
        nxt       = st;
        tmr_rst   = 1'b0;
        setup_hit = 1'b0;
        hold_hit  = 1'b0;
        gap_hit   = 1'b0;
        stray_hit = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (cs_fall) begin
                    tmr_rst = 1'b1;
                    if (sck_edge) begin
                        setup_hit = 1'b1;
                        nxt       = ST_CLOCKING;
                    end else begin
                        nxt = ST_ARMED;
                    end
                end else if (sck_edge) begin
                    stray_hit = 1'b1;
                end
            end
            ST_ARMED: begin
                if (cs_rise) begin
                    hold_hit = sck_edge;
                    tmr_rst  = 1'b1;
                    nxt      = ST_RECOVER;
                end else if (sck_edge) begin
                    setup_hit = (tmr < LIM_SETUP);
                    tmr_rst   = 1'b1;
                    nxt       = ST_CLOCKING;
                end
            end
            ST_CLOCKING: begin
                if (cs_rise) begin
                    hold_hit = sck_edge || (tmr < LIM_HOLD);
                    tmr_rst  = 1'b1;
                    nxt      = ST_RECOVER;
                end else if (sck_edge) begin
                    tmr_rst = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cs_fall) begin
                    gap_hit = (tmr < LIM_GAP);
                    tmr_rst = 1'b1;
                    if (sck_edge) begin
                        setup_hit = 1'b1;
                        nxt       = ST_CLOCKING;
                    end else begin
                        nxt = ST_ARMED;
                    end
                end else begin
                    stray_hit = sck_edge;
                    if (tmr >= LIM_GAP) nxt = ST_IDLE;
                end
            end
        endcase
    end

    // state register and spacing timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            tmr <= '0;
        end else begin
            st <= nxt;
            if (tmr_rst)             tmr <= CW'(1);
            else if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
        end
    end

    always_comb begin
        hits            = '0;
        hits[FLG_HI]    = hi_short;
        hits[FLG_LO]    = lo_short;
        hits[FLG_PER]   = per_short;
        hits[FLG_SETUP] = setup_hit;
        hits[FLG_HOLD]  = hold_hit;
        hits[FLG_GAP]   = gap_hit;
        hits[FLG_STRAY] = stray_hit;
    end

    // sticky flag outputs; a fresh hit wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= '0;
        else        viol <= (clr ? '0 : viol) | hits;
    end
endmodule

// File: rtl/stm_checker.sv
`timescale 1ns/1ps
module stm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       cs_n,
    input logic [6:0] viol,
    input logic       word_done
);
    a_r9_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((viol & $past(viol)) == $past(viol)));

    a_r5_setup_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[3]) |-> !$past(cs_n));

    a_r6_hold_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[4]) |-> $past(cs_n));

    a_r7_gap_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[5]) |-> !$past(cs_n));

    a_r8_stray_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[6]) |-> $past(cs_n));

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    a_r10_done_after_selected: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> !$past(cs_n));
endmodule

bind sspi_timing_mon stm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .cs_n      (cs_n),
    .viol      (viol),
    .word_done (word_done)
);

// File: tb/tb_sspi_timing_mon.sv
`timescale 1ns/1ps
module tb_sspi_timing_mon;
    localparam int P_HI = 2, P_LO = 2, P_PER = 4, P_SU = 2, P_HO = 2, P_GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic [6:0] viol;
    logic       word_done;
    logic [7:0] rx_word;

    int n_chk = 0, n_bad = 0, done_seen = 0;
    logic [7:0] last_word = '0;

    sspi_timing_mon dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cpol(cpol), .cpha(cpha), .viol(viol), .word_done(word_done), .rx_word(rx_word)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic m, input logic k);
        @(negedge clk);
        cs_n = c; sck = s; mosi = m; clr = k;
        @(posedge clk);
        #1;
        if (word_done) begin
            done_seen++;
            last_word = rx_word;
        end
    endtask

    function automatic logic bitof(input logic [7:0] d, input int k);
        return (k < 8) ? d[7-k] : 1'b0;
    endfunction

    // g-1 idle steps (rise step of previous transfer counts as the first),
    // su selected idle steps, 2*nb edges, ho steps after the last edge, then release
    task automatic xfer(input int hi, input int lo, input int su, input int ho, input int g,
                        input int nb, input logic doclr, input logic [7:0] d);
        logic lvl;
        int   k;
        lvl = cpol;
        k = 0;
        done_seen = 0;
        for (int i = 0; i < g - 1; i++) step(1'b1, lvl, 1'b0, doclr && (i == 0));
        for (int i = 0; i < su; i++) step(1'b0, lvl, bitof(d, k), 1'b0);
        for (int e = 0; e < 2 * nb; e++) begin
            logic bt, last, smp_e;
            int   len;
            lvl   = ~lvl;
            last  = (e == 2 * nb - 1);
            smp_e = (cpha == 1'b0) ? (e % 2 == 0) : (e % 2 == 1);
            len   = last ? ho : (lvl ? hi : lo);
            bt    = bitof(d, k);
            if (last && ho == 0) begin
                step(1'b1, lvl, bt, 1'b0);
            end else begin
                step(1'b0, lvl, bt, 1'b0);
                if (smp_e) k++;
                for (int j = 1; j < len; j++) step(1'b0, lvl, bitof(d, k), 1'b0);
                if (last) step(1'b1, lvl, 1'b0, 1'b0);
            end
        end
    endtask

    task automatic set_mode(input int m);
        cpol = m[1];
        cpha = m[0];
        step(1'b1, cpol, 1'b0, 1'b0);
        step(1'b1, cpol, 1'b0, 1'b0);
        step(1'b1, cpol, 1'b0, 1'b0);
        step(1'b1, cpol, 1'b0, 1'b1);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        check("R1 flags", 32'(viol), 32'h0);
        check("R1 word_done", 32'(word_done), 32'h0);

        // sweep: R2 R3 R4 R5 R6 R10 R11 over all modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m);
            for (int hi = 1; hi <= 3; hi++)
            for (int lo = 1; lo <= 3; lo++)
            for (int su = 0; su <= 3; su++)
            for (int ho = 0; ho <= 3; ho++) begin
                logic [7:0] d;
                logic [6:0] ev;
                int         ew;
                d  = 8'(hi * 53 + lo * 29 + su * 7 + ho * 3 + m * 91 + 90);
                ev = '0;
                ev[0] = (hi < P_HI);
                ev[1] = (lo < P_LO);
                ev[2] = (hi + lo < P_PER);
                ev[3] = (su < P_SU);
                ev[4] = (ho < P_HO);
                ew = (cpha == 1'b1 && ho == 0) ? 0 : 1;
                xfer(hi, lo, su, ho, 3, 8, 1'b1, d);
                if (hi == 2 && lo == 2 && su == 2 && ho == 2)
                    check("R11 compliant no flag", 32'(viol), 32'h0);
                else
                    check("R2 R3 R4 R5 R6 flag pattern", 32'(viol), 32'(ev));
                check("R10 word count", 32'(done_seen), 32'(ew));
                if (ew == 1) check("R10 MSB-first word", 32'(last_word), 32'(d));
            end
        end

        // R7: gap rule
        set_mode(0);
        xfer(2, 2, 2, 2, 3, 8, 1'b1, 8'h11);
        xfer(2, 2, 2, 2, 1, 8, 1'b0, 8'h22);
        check("R7 gap of 1", 32'(viol), 32'h20);
        xfer(2, 2, 2, 2, 2, 8, 1'b1, 8'h33);
        check("R7 gap of 2 ok", 32'(viol), 32'h0);
        check("R7 word after gap", 32'(last_word), 32'h33);

        // R9: clear versus fresh violation in the same cycle
        xfer(2, 2, 2, 2, 1, 8, 1'b0, 8'h44);
        check("R9 gap flag before clear", 32'(viol), 32'h20);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R9 set wins over clear", 32'(viol), 32'h40);

        // R8: stray edges while deselected, no width flags although 1-cycle phases
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R9 clear", 32'(viol), 32'h0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 stray only", 32'(viol), 32'h40);

        // R9: flag stays through a clean transfer without clear
        xfer(2, 2, 2, 2, 3, 8, 1'b0, 8'h5C);
        check("R9 sticky", 32'(viol), 32'h40);
        check("R9 word still delivered", 32'(last_word), 32'h5C);

        // R12: aborted word then a full one, in two modes
        for (int m = 1; m <= 2; m++) begin
            set_mode(m);
            xfer(2, 2, 2, 2, 3, 3, 1'b1, 8'hE0);
            check("R12 no word on abort", 32'(done_seen), 32'h0);
            xfer(2, 2, 2, 2, 3, 8, 1'b1, 8'h96);
            check("R12 count restarts", 32'(done_seen), 32'h1);
            check("R12 word after abort", 32'(last_word), 32'h96);
            check("R12 no flags", 32'(viol), 32'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule